// File: doc/BRIEF.md
# Parallel Port Handshake Control Register

This block holds the 16-bit configuration and command word of a Centronics-style parallel port. It generates the port's handshake outputs. Software reads and writes the word over a simple register bus that has an address, a write enable, write data and read data. Several bits in the word are commands rather than settings:

- **Start.** Raises a one-cycle request that makes the transmit descriptor poller look at its descriptor.
- **Force acknowledge.** Drives the active-low ACK output low.
- **Force BUSY low.** Drives the BUSY line to 0.
- **Force BUSY high.** Drives the BUSY line to 1.

The start command clears itself after one clock. The two BUSY commands stay pending until the BUSY output has actually reached the commanded level, and then they clear themselves.

In receive mode with BUSY generation enabled, the BUSY output tracks the port engine's busy state and goes high on an incoming strobe. The output enable for the BUSY pin needs three things: generation is enabled, the pin-mux bit gives the pin to the port, and the direction bit makes it an output. While generation is disabled, strobes have no effect. They keep having no effect until software issues a force-low command, even after generation is enabled again.

The mode field is stored and read back only.

Top module: `pport_hsk_ctrl`

## Requirements
- R1: After reset the register reads 0x0000, busyOut is 0, busyOe is 0, ackOutN is 1 and txPollReq is 0.
- R2: A write at the register address stores bit 11 (force ACK), bit 10 (force BUSY low), bit 9 (force BUSY high), bit 8 (BUSY enable), bits 7..1 (mode) and bit 0 (1 = transmit, 0 = receive), and they read back. Bits 14..12 always read 0. Writes to other addresses change nothing, and reads of other addresses return 0.
- R3: A write with bit 15 and bit 0 both set makes txPollReq 1 for exactly the cycle after the write, with bit 15 reading 1 in that cycle and 0 afterwards. If bit 0 is 0 in the written value, bit 15 is not stored and no request is raised.
- R4: While bit 11 is 1, ackOutN is 0; otherwise it is 1.
- R5: In receive mode, a pending bit 10 drives busyOut to 0 on the next clock. Bit 10 clears on the first clock at which busyOut is already 0.
- R6: In receive mode, a pending bit 9 drives busyOut to 1 on the next clock. Bit 9 clears on the first clock at which busyOut is already 1.
- R7: A write with bits 10 and 9 both set stores bit 10 and drops bit 9, so bit 9 reads 0 immediately.
- R8: In transmit mode, bits 9 and 10 clear on the next clock and busyOut is driven to 0.
- R9: busyOe is 1 exactly when receive mode, bit 8 = 1, pinMuxSel = 0 and pinDirOut = 1.
- R10: In receive mode, with bit 8 = 1, strobes accepted and no BUSY command pending, busyOut takes engineBusy OR strobeIn one clock later.
- R11: While bit 8 is 0, strobes are ignored. They stay ignored (busyOut holds) after bit 8 is set again, until a bit 10 command has been applied. Strobes are ignored from reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register bus address |
| regWe | input | 1 | Register bus write enable |
| regWdata | input | 16 | Register bus write data |
| regRdata | output | 16 | Register bus read data, 0 when the address does not match |
| strobeIn | input | 1 | Data strobe seen on the port (1 = strobe active) |
| engineBusy | input | 1 | Busy state reported by the port engine |
| pinMuxSel | input | 1 | Pin-mux bit for the BUSY pin (0 = pin belongs to the port) |
| pinDirOut | input | 1 | Direction bit for the BUSY pin (1 = output) |
| busyOut | output | 1 | BUSY handshake output level |
| busyOe | output | 1 | Output enable for the BUSY pin |
| ackOutN | output | 1 | Active-low ACK handshake output |
| txPollReq | output | 1 | One-cycle transmit descriptor poll request |

## Verification
The bench builds the block with ADDR_W = 3 and the register placed at address 5 instead of the defaults. A narrower bus makes every other address cheap to reach, so a write and a read at a neighbouring address can show that the decoder rejects them.

With that placement, the directed scenarios drive the self-clearing bits through both of their paths:
- with busyOut already at the commanded level, the bit clears after one clock;
- with busyOut at the opposite level, the bit stays pending for an extra clock.

The scenarios also exercise the strobe-ignore latch across a disable and re-enable of BUSY generation.

// File: rtl/pport_hsk_pkg.sv
package pport_hsk_pkg;

  localparam int REG_W     = 16;
  localparam int START_BIT = 15;
  localparam int ACK_BIT   = 11;
  localparam int CLR_BIT   = 10;
  localparam int SET_BIT   = 9;
  localparam int EN_BIT    = 8;
  localparam int MODE_HI   = 7;
  localparam int MODE_LO   = 1;
  localparam int TX_BIT    = 0;
  localparam int MODE_W    = MODE_HI - MODE_LO + 1;

  // Register fields the control logic reacts to
  typedef struct packed {
    logic start;
    logic ackSet;
    logic busyClr;
    logic busySet;
    logic busyEn;
    logic txMode;
  } ctlFields_t;

  // Self-clear requests from control to the register datapath
  typedef struct packed {
    logic dropStart;
    logic dropClr;
    logic dropSet;
  } ctlStrobes_t;

endpackage

// File: rtl/pport_hsk_regs.sv
module pport_hsk_regs
  import pport_hsk_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [REG_W-1:0]  regWdata,
  input  ctlStrobes_t       strobes,
  output logic [REG_W-1:0]  regRdata,
  output ctlFields_t        fields
);

  logic              startQ, ackQ, clrQ, setQ, enQ, txQ;
  logic [MODE_W-1:0] modeQ;
  logic              addrHit, wrHit;
  logic [REG_W-1:0]  regImage;

  assign addrHit = (regAddr == REG_ADDR);
  assign wrHit   = regWe && addrHit;

  // Mode field: plain storage, one flop per bit
  for (genvar gi = 0; gi < MODE_W; gi++) begin : g_mode
    always_ff @(posedge clk) begin
      if (!rstN)      modeQ[gi] <= 1'b0;
      else if (wrHit) modeQ[gi] <= regWdata[MODE_LO + gi];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= 1'b0;
      ackQ   <= 1'b0;
      clrQ   <= 1'b0;
      setQ   <= 1'b0;
      enQ    <= 1'b0;
      txQ    <= 1'b0;
    end else if (wrHit) begin
      txQ    <= regWdata[TX_BIT];
      startQ <= regWdata[START_BIT] & regWdata[TX_BIT];
      ackQ   <= regWdata[ACK_BIT];
      clrQ   <= regWdata[CLR_BIT];
      setQ   <= regWdata[SET_BIT] & ~regWdata[CLR_BIT];
      enQ    <= regWdata[EN_BIT];
    end else begin
      if (strobes.dropStart) startQ <= 1'b0;
      if (strobes.dropClr)   clrQ   <= 1'b0;
      if (strobes.dropSet)   setQ   <= 1'b0;
    end
  end

  always_comb begin
    regImage                  = '0;
    regImage[START_BIT]       = startQ;
    regImage[ACK_BIT]         = ackQ;
    regImage[CLR_BIT]         = clrQ;
    regImage[SET_BIT]         = setQ;
    regImage[EN_BIT]          = enQ;
    regImage[MODE_HI:MODE_LO] = modeQ;
    regImage[TX_BIT]          = txQ;
  end

  assign regRdata = addrHit ? regImage : '0;

  assign fields.start   = startQ;
  assign fields.ackSet  = ackQ;
  assign fields.busyClr = clrQ;
  assign fields.busySet = setQ;
  assign fields.busyEn  = enQ;
  assign fields.txMode  = txQ;

  // R3
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startQ && !wrHit) |=> !startQ);

  // R3
  start_needs_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    startQ |-> txQ);

  // R7
  no_dual_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(clrQ && setQ));

endmodule

// File: rtl/pport_hsk_ctl.sv
module pport_hsk_ctl
  import pport_hsk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctlFields_t  fields,
  input  logic        strobeIn,
  input  logic        engineBusy,
  input  logic        pinMuxSel,
  input  logic        pinDirOut,
  output logic        busyOut,
  output logic        busyOe,
  output logic        ackOutN,
  output logic        txPollReq,
  output ctlStrobes_t strobes
);

  logic busyQ, ignoreQ, busyNext, ignoreNext, rxMode, genLive;

  assign rxMode  = !fields.txMode;
  assign genLive = rxMode && fields.busyEn && !ignoreQ;

  always_comb begin
    if (!rxMode)              busyNext = 1'b0;
    else if (fields.busyClr)  busyNext = 1'b0;
    else if (fields.busySet)  busyNext = 1'b1;
    else if (genLive)         busyNext = engineBusy | strobeIn;
    else                      busyNext = busyQ;
  end

  always_comb begin
    if (rxMode && fields.busyClr) ignoreNext = 1'b0;
    else if (!fields.busyEn)      ignoreNext = 1'b1;
    else                          ignoreNext = ignoreQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      ignoreQ <= 1'b1;
    end else begin
      busyQ   <= busyNext;
      ignoreQ <= ignoreNext;
    end
  end

  assign strobes.dropStart = fields.start;
  assign strobes.dropClr   = fields.busyClr && (!rxMode || !busyQ);
  assign strobes.dropSet   = fields.busySet && (!rxMode || busyQ);

  assign busyOut   = busyQ;
  assign busyOe    = rxMode && fields.busyEn && !pinMuxSel && pinDirOut;
  assign ackOutN   = !fields.ackSet;
  assign txPollReq = fields.start;

  // R5
  clr_forces_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxMode && fields.busyClr) |=> !busyOut);

  // R6
  set_forces_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxMode && fields.busySet && !fields.busyClr) |=> busyOut);

  // R8
  tx_busy_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxMode |=> !busyOut);

  // R11
  ignore_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxMode && ignoreQ && !fields.busyClr && !fields.busySet) |=> $stable(busyOut));

endmodule

// File: rtl/pport_hsk_ctrl.sv
module pport_hsk_ctrl
  import pport_hsk_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  input  logic              strobeIn,
  input  logic              engineBusy,
  input  logic              pinMuxSel,
  input  logic              pinDirOut,
  output logic              busyOut,
  output logic              busyOe,
  output logic              ackOutN,
  output logic              txPollReq
);

  ctlFields_t  fields;
  ctlStrobes_t strobes;

  pport_hsk_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWe    (regWe),
    .regWdata (regWdata),
    .strobes  (strobes),
    .regRdata (regRdata),
    .fields   (fields)
  );

  pport_hsk_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .fields     (fields),
    .strobeIn   (strobeIn),
    .engineBusy (engineBusy),
    .pinMuxSel  (pinMuxSel),
    .pinDirOut  (pinDirOut),
    .busyOut    (busyOut),
    .busyOe     (busyOe),
    .ackOutN    (ackOutN),
    .txPollReq  (txPollReq),
    .strobes    (strobes)
  );

endmodule

// File: tb/pport_hsk_ctrl_test.sv
`timescale 1ns/1ps
module pport_hsk_ctrl_test;

  localparam int unsigned AW = 3;
  localparam logic [AW-1:0] RADDR = 3'd5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] regAddr = RADDR;
  logic          regWe = 1'b0;
  logic [15:0]   regWdata = '0;
  logic [15:0]   regRdata;
  logic          strobeIn = 1'b0, engineBusy = 1'b0, pinMuxSel = 1'b0, pinDirOut = 1'b1;
  logic          busyOut, busyOe, ackOutN, txPollReq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pport_hsk_ctrl #(.ADDR_W(AW), .REG_ADDR(RADDR)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .strobeIn(strobeIn),
    .engineBusy(engineBusy), .pinMuxSel(pinMuxSel), .pinDirOut(pinDirOut),
    .busyOut(busyOut), .busyOe(busyOe), .ackOutN(ackOutN), .txPollReq(txPollReq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drives a write across one rising edge; returns at the next falling edge
  task automatic writeAt(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWe = 1'b1; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regAddr = RADDR;
  endtask

  task automatic readCheck(input string req, input logic [AW-1:0] a, input logic [15:0] exp);
    regAddr = a;
    #1;
    check(req, regRdata, exp);
    regAddr = RADDR;
  endtask

  task automatic testReset();
    readCheck("R1 reg", RADDR, 16'h0000);
    check("R1 busyOut", {15'd0, busyOut}, 16'd0);
    check("R1 busyOe", {15'd0, busyOe}, 16'd0);
    check("R1 ackOutN", {15'd0, ackOutN}, 16'd1);
    check("R1 txPollReq", {15'd0, txPollReq}, 16'd0);
  endtask

  task automatic testReadWrite();
    writeAt(RADDR, 16'h70FE);
    readCheck("R2 reserved/mode", RADDR, 16'h00FE);
    writeAt(3'd2, 16'h0001);
    readCheck("R2 other addr write ignored", RADDR, 16'h00FE);
    readCheck("R2 other addr reads zero", 3'd2, 16'h0000);
    writeAt(RADDR, 16'h0000);
  endtask

  task automatic testStart();
    writeAt(RADDR, 16'h8001);
    check("R3 poll high", {15'd0, txPollReq}, 16'd1);
    readCheck("R3 start reads 1", RADDR, 16'h8001);
    step(1);
    check("R3 poll low", {15'd0, txPollReq}, 16'd0);
    readCheck("R3 start cleared", RADDR, 16'h0001);
    writeAt(RADDR, 16'h8000);
    check("R3 rx start no poll", {15'd0, txPollReq}, 16'd0);
    readCheck("R3 rx start dropped", RADDR, 16'h0000);
  endtask

  task automatic testAck();
    writeAt(RADDR, 16'h0800);
    check("R4 ack low", {15'd0, ackOutN}, 16'd0);
    writeAt(RADDR, 16'h0000);
    check("R4 ack high", {15'd0, ackOutN}, 16'd1);
  endtask

  task automatic testGenAndIgnore();
    engineBusy = 1'b1;
    writeAt(RADDR, 16'h0100);
    step(2);
    check("R11 ignored after enable", {15'd0, busyOut}, 16'd0);
    pinMuxSel = 1'b0; pinDirOut = 1'b1; #1;
    check("R9 oe on", {15'd0, busyOe}, 16'd1);
    pinMuxSel = 1'b1; #1;
    check("R9 oe mux", {15'd0, busyOe}, 16'd0);
    pinMuxSel = 1'b0; pinDirOut = 1'b0; #1;
    check("R9 oe dir", {15'd0, busyOe}, 16'd0);
    pinDirOut = 1'b1;
    engineBusy = 1'b0;
    writeAt(RADDR, 16'h0500);
    step(1);
    readCheck("R5 clr drops at once when low", RADDR, 16'h0100);
    step(1);
    engineBusy = 1'b1;
    step(1);
    check("R10 follows engine", {15'd0, busyOut}, 16'd1);
    engineBusy = 1'b0;
    step(1);
    check("R10 engine release", {15'd0, busyOut}, 16'd0);
    strobeIn = 1'b1;
    step(1);
    strobeIn = 1'b0;
    check("R10 strobe raises", {15'd0, busyOut}, 16'd1);
    step(1);
    check("R10 strobe gone", {15'd0, busyOut}, 16'd0);
  endtask

  task automatic testSetClr();
    writeAt(RADDR, 16'h0300);
    check("R6 not yet high", {15'd0, busyOut}, 16'd0);
    step(1);
    check("R6 high", {15'd0, busyOut}, 16'd1);
    readCheck("R6 still pending", RADDR, 16'h0300);
    step(1);
    readCheck("R6 cleared", RADDR, 16'h0100);
    check("R6 held", {15'd0, busyOut}, 16'd1);
    engineBusy = 1'b1;
    step(2);
    writeAt(RADDR, 16'h0500);
    check("R5 still high", {15'd0, busyOut}, 16'd1);
    step(1);
    check("R5 low", {15'd0, busyOut}, 16'd0);
    readCheck("R5 pending", RADDR, 16'h0500);
    step(1);
    readCheck("R5 cleared", RADDR, 16'h0100);
    check("R5 held low", {15'd0, busyOut}, 16'd0);
    engineBusy = 1'b0;
  endtask

  task automatic testBoth();
    writeAt(RADDR, 16'h0700);
    readCheck("R7 set dropped", RADDR, 16'h0500);
    step(2);
    check("R7 busy low", {15'd0, busyOut}, 16'd0);
  endtask

  task automatic testTx();
    writeAt(RADDR, 16'h0301);
    readCheck("R8 accepted", RADDR, 16'h0301);
    check("R9 oe off in tx", {15'd0, busyOe}, 16'd0);
    step(1);
    readCheck("R8 cleared", RADDR, 16'h0101);
    check("R8 busy low", {15'd0, busyOut}, 16'd0);
  endtask

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    testReset();
    testReadWrite();
    testStart();
    testAck();
    testGenAndIgnore();
    testSetClr();
    testBoth();
    testTx();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule